// File: doc/BRIEF.md
# I2C Host Register Front End

This block sits between a simple register bus and a byte-level I2C bus engine. Software works through five 8-bit registers: own address, clock divider, control, status and data. Writes and reads of the data register become engine commands: start with an address byte, send a byte, receive a byte, or stop. The engine answers each command with a done pulse that carries an ack flag, an arbitration-lost flag and, for receives, a byte.

The block tracks whether a transfer is open. The first data write after the transfer closes goes out as the address byte. When the enable bit is cleared, a soft reset clears every register except the own address. Status flags are cleared only when software writes zero to them. A register access that launches a command holds `ready_o` low until the engine reports done. An access that needs no command completes in the cycle it is presented. The interrupt is a level output that follows the pending flag.

Top module: `i2c_host_regs`

## Requirements
- R1: After reset every register reads 0x00, `irq_o` is low and no command is issued.
- R2: Offsets are own address 0x00, divider 0x04, control 0x08, status 0x0C and data 0x10. Only write bits 7:0 are used. The own address keeps bits 7:1 (mask 0xFE) and the divider keeps bits 5:0 (mask 0x3F). The control register keeps bits 7:2: enable 7, interrupt-enable 6, master 5, transmit 4, repeated-start 2. An unmapped read returns 0 and an unmapped write changes nothing.
- R3: A control write that is not a soft reset sets status bit 5 (busy) when master is 1 and clears it when master is 0.
- R4: When enabled in master mode with no open transfer, a data write issues START (op 0) with the written byte. On ack the transfer opens, status bit 0 (nack) clears and an interrupt is raised. On nack, bit 0 is set and the transfer stays closed.
- R5: A data write while a transfer is open issues WRITE (op 1). On ack, nack clears and an interrupt is raised. On nack, nack is set, STOP (op 3) follows and the transfer closes.
- R6: A data read in master mode with an open transfer and transmit 0 issues READ (op 2) and returns the received byte. A failed read returns 0xFF. In master mode with no open transfer or with transmit 1, the read returns 0xFF with no command. Outside master mode it returns the stored data value.
- R7: Raising an interrupt sets status bit 1 (pending) and drives `irq_o` high only when both enable and interrupt-enable are 1.
- R8: Writing 0 to status bit 1 clears it and lowers `irq_o`. Writing 0 to status bit 4 (arbitration lost) clears it. Writing 1 to either bit leaves it unchanged.
- R9: A control write with master 0 while a transfer is open issues STOP and closes the transfer.
- R10: A control write with master 1 and repeated-start 1 while a transfer is open issues STOP, closes the transfer and reads back with bit 2 cleared. With no open transfer, bit 2 stays set.
- R11: A control write with enable 0 while enabled resets divider, control, status and data to 0, keeps the own address, and issues STOP if a transfer was open.
- R12: A data write while disabled issues no command and changes no status.
- R13: A command access keeps `ready_o` low until one cycle after the engine's done. A command stays valid and stable until the engine accepts it.
- R14: A done reported with arbitration lost sets status bit 4 and counts as a nack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access request, held until ready_o |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | BUS_W | Write data; bits 7:0 used |
| rdata_o | output | BUS_W | Read data, valid with ready_o |
| ready_o | output | 1 | Access completes on this cycle |
| cmd_valid_o | output | 1 | Engine command valid |
| cmd_ready_i | input | 1 | Engine accepts the command |
| cmd_op_o | output | 2 | 0 start, 1 write, 2 read, 3 stop |
| cmd_data_o | output | 8 | Address or data byte for the command |
| eng_done_i | input | 1 | Engine finished the accepted command |
| eng_ack_i | input | 1 | Ack received, valid with done |
| eng_lost_i | input | 1 | Arbitration lost, valid with done |
| eng_rdata_i | input | 8 | Received byte, valid with done |
| div_o | output | DIV_W | Divider value for the engine |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench sweeps every byte value through the masked registers and through the address phase, with ack or nack chosen by a rule on the byte. A design that decoded the address phase wrongly would issue WRITE where START belongs, or would open a transfer after a nack. The send tests check that a nack is followed by exactly one STOP, then a fresh START. A design that failed to chain the stop would leave the bus held open. The bench also checks the repeated-start self-clear against the case with no open transfer, and checks that a soft reset spares the own address. It checks that a status write of 1s leaves the flags in place. A design with inverted write-zero clearing would drop the interrupt on that write.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
  typedef enum logic [1:0] {OP_START = 2'd0, OP_WRITE = 2'd1, OP_READ = 2'd2, OP_STOP = 2'd3} op_e;
  typedef enum logic [2:0] {SEL_OWN, SEL_DIV, SEL_CTRL, SEL_STAT, SEL_DATA, SEL_NONE} sel_e;

  localparam int CTL_EN   = 7;
  localparam int CTL_IEN  = 6;
  localparam int CTL_MST  = 5;
  localparam int CTL_TX   = 4;
  localparam int CTL_RSTA = 2;

  localparam int ST_BUSY = 5;
  localparam int ST_AL   = 4;
  localparam int ST_IIF  = 1;
  localparam int ST_NACK = 0;

  localparam logic [7:0] OWN_MASK = 8'hFE;
  localparam logic [7:0] CTL_MASK = 8'hFC;
  localparam logic [7:0] BYTE_IDLE = 8'hFF;
endpackage

// File: rtl/i2c_rf_decode.sv
module i2c_rf_decode
  import i2c_rf_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] OFF_OWN  = 'h00,
  parameter logic [ADDR_W-1:0] OFF_DIV  = 'h04,
  parameter logic [ADDR_W-1:0] OFF_CTRL = 'h08,
  parameter logic [ADDR_W-1:0] OFF_STAT = 'h0C,
  parameter logic [ADDR_W-1:0] OFF_DATA = 'h10
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sel_e              sel_o
);
  always_comb begin
    if (addr_i == OFF_OWN)       sel_o = SEL_OWN;
    else if (addr_i == OFF_DIV)  sel_o = SEL_DIV;
    else if (addr_i == OFF_CTRL) sel_o = SEL_CTRL;
    else if (addr_i == OFF_STAT) sel_o = SEL_STAT;
    else if (addr_i == OFF_DATA) sel_o = SEL_DATA;
    else                         sel_o = SEL_NONE;
  end
endmodule

// File: rtl/i2c_rf_seq.sv
module i2c_rf_seq
  import i2c_rf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       launch_i,
  input  op_e        launch_op_i,
  input  logic [7:0] launch_byte_i,
  input  logic       follow_i,
  output logic       cmd_valid_o,
  input  logic       cmd_ready_i,
  output op_e        cmd_op_o,
  output logic [7:0] cmd_data_o,
  input  logic       eng_done_i,
  output logic       done_o,
  output logic       idle_o,
  output logic       resp_o
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_RESP} state_e;
  state_e     state_q;
  op_e        op_q;
  logic [7:0] byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= OP_STOP;
      byte_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (launch_i) begin
          state_q <= S_ISSUE;
          op_q    <= launch_op_i;
          byte_q  <= launch_byte_i;
        end
        S_ISSUE: if (cmd_ready_i) state_q <= S_WAIT;
        S_WAIT: if (eng_done_i) begin
          if (follow_i) begin
            // chained stop after a refused data byte
            state_q <= S_ISSUE;
            op_q    <= OP_STOP;
            byte_q  <= '0;
          end else begin
            state_q <= S_RESP;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cmd_valid_o = (state_q == S_ISSUE);
  assign cmd_op_o    = op_q;
  assign cmd_data_o  = byte_q;
  assign done_o      = (state_q == S_WAIT) && eng_done_i;
  assign idle_o      = (state_q == S_IDLE);
  assign resp_o      = (state_q == S_RESP);
endmodule

// File: rtl/i2c_rf_regs.sv
module i2c_rf_regs
  import i2c_rf_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             we_i,
  input  sel_e             sel_i,
  input  logic [7:0]       wdata_i,
  input  logic             done_i,
  input  op_e              cur_op_i,
  input  logic             eng_ack_i,
  input  logic             eng_lost_i,
  input  logic [7:0]       eng_rdata_i,
  input  logic             resp_i,
  output logic             launch_o,
  output op_e              launch_op_o,
  output logic [7:0]       launch_byte_o,
  output logic             follow_o,
  output logic [7:0]       rdata_o,
  output logic [DIV_W-1:0] div_o,
  output logic             irq_o
);
  localparam int PAD_W = 8 - DIV_W;

  logic [7:0]       own_q, ctrl_q, rd_q;
  logic [DIV_W-1:0] div_q;
  logic             busy_q, al_q, iif_q, nack_q, open_q;

  logic en, ien, mst, tx;
  logic wr_acc, rd_acc, soft_rst, ctl_norm, rd_fetch, ack_ok, raise;
  logic [7:0] ctl_new, stat_w;

  assign en  = ctrl_q[CTL_EN];
  assign ien = ctrl_q[CTL_IEN];
  assign mst = ctrl_q[CTL_MST];
  assign tx  = ctrl_q[CTL_TX];

  assign wr_acc   = acc_i && we_i;
  assign rd_acc   = acc_i && !we_i;
  assign soft_rst = wr_acc && (sel_i == SEL_CTRL) && en && !wdata_i[CTL_EN];
  assign ctl_norm = wr_acc && (sel_i == SEL_CTRL) && !soft_rst;
  assign rd_fetch = mst && open_q && !tx;
  assign ack_ok   = eng_ack_i && !eng_lost_i;
  assign raise    = en && ien;

  always_comb begin
    ctl_new = wdata_i & CTL_MASK;
    if (ctl_new[CTL_MST] && ctl_new[CTL_RSTA] && open_q) ctl_new[CTL_RSTA] = 1'b0;
  end

  always_comb begin
    launch_o      = 1'b0;
    launch_op_o   = OP_STOP;
    launch_byte_o = '0;
    if (wr_acc && (sel_i == SEL_DATA) && en && mst) begin
      launch_o      = 1'b1;
      launch_op_o   = open_q ? OP_WRITE : OP_START;
      launch_byte_o = wdata_i;
    end else if (soft_rst && open_q) begin
      launch_o = 1'b1;
    end else if (ctl_norm && open_q && (!wdata_i[CTL_MST] || wdata_i[CTL_RSTA])) begin
      launch_o = 1'b1;
    end else if (rd_acc && (sel_i == SEL_DATA) && rd_fetch) begin
      launch_o    = 1'b1;
      launch_op_o = OP_READ;
    end
  end

  assign follow_o = done_i && (cur_op_i == OP_WRITE) && !ack_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q  <= '0;
      div_q  <= '0;
      ctrl_q <= '0;
      rd_q   <= '0;
      busy_q <= 1'b0;
      al_q   <= 1'b0;
      iif_q  <= 1'b0;
      nack_q <= 1'b0;
      open_q <= 1'b0;
    end else begin
      if (wr_acc) begin
        case (sel_i)
          SEL_OWN: own_q <= wdata_i & OWN_MASK;
          SEL_DIV: div_q <= wdata_i[DIV_W-1:0];
          SEL_CTRL: begin
            if (soft_rst) begin
              div_q  <= '0;
              ctrl_q <= '0;
              rd_q   <= '0;
              busy_q <= 1'b0;
              al_q   <= 1'b0;
              iif_q  <= 1'b0;
              nack_q <= 1'b0;
              open_q <= 1'b0;
            end else begin
              ctrl_q <= ctl_new;
              busy_q <= wdata_i[CTL_MST];
              if (!wdata_i[CTL_MST] || wdata_i[CTL_RSTA]) open_q <= 1'b0;
            end
          end
          SEL_STAT: begin
            if (!wdata_i[ST_IIF]) iif_q <= 1'b0;
            if (!wdata_i[ST_AL])  al_q  <= 1'b0;
          end
          default: ;
        endcase
      end
      if (rd_acc && (sel_i == SEL_DATA) && mst && !rd_fetch) rd_q <= BYTE_IDLE;
      if (done_i) begin
        if (eng_lost_i) al_q <= 1'b1;
        case (cur_op_i)
          OP_START: begin
            nack_q <= !ack_ok;
            if (ack_ok) begin
              open_q <= 1'b1;
              if (raise) iif_q <= 1'b1;
            end
          end
          OP_WRITE: begin
            nack_q <= !ack_ok;
            if (ack_ok) begin
              if (raise) iif_q <= 1'b1;
            end else begin
              open_q <= 1'b0;
            end
          end
          OP_READ: begin
            rd_q <= ack_ok ? eng_rdata_i : BYTE_IDLE;
            if (ack_ok && raise) iif_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    stat_w          = '0;
    stat_w[ST_BUSY] = busy_q;
    stat_w[ST_AL]   = al_q;
    stat_w[ST_IIF]  = iif_q;
    stat_w[ST_NACK] = nack_q;
  end

  always_comb begin
    if (resp_i) begin
      rdata_o = rd_q;
    end else begin
      case (sel_i)
        SEL_OWN:  rdata_o = own_q;
        SEL_DIV:  rdata_o = {{PAD_W{1'b0}}, div_q};
        SEL_CTRL: rdata_o = ctrl_q;
        SEL_STAT: rdata_o = stat_w;
        SEL_DATA: rdata_o = (mst && !rd_fetch) ? BYTE_IDLE : rd_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign div_o = div_q;
  assign irq_o = iif_q;
endmodule

// File: rtl/i2c_host_regs.sv
module i2c_host_regs
  import i2c_rf_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int BUS_W  = 16,
  parameter int DIV_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              ready_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [1:0]        cmd_op_o,
  output logic [7:0]        cmd_data_o,
  input  logic              eng_done_i,
  input  logic              eng_ack_i,
  input  logic              eng_lost_i,
  input  logic [7:0]        eng_rdata_i,
  output logic [DIV_W-1:0]  div_o,
  output logic              irq_o
);
  localparam int HI_W = BUS_W - 8;

  sel_e       sel_w;
  op_e        launch_op_w, cmd_op_w;
  logic [7:0] launch_byte_w, rdata_w;
  logic       launch_w, follow_w, done_w, idle_w, resp_w, acc_w;
  logic       unused_hi;

  assign unused_hi = ^wdata_i[BUS_W-1:8];
  assign acc_w     = idle_w && req_i;

  i2c_rf_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel_w)
  );

  i2c_rf_seq u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .launch_i      (launch_w),
    .launch_op_i   (launch_op_w),
    .launch_byte_i (launch_byte_w),
    .follow_i      (follow_w),
    .cmd_valid_o   (cmd_valid_o),
    .cmd_ready_i   (cmd_ready_i),
    .cmd_op_o      (cmd_op_w),
    .cmd_data_o    (cmd_data_o),
    .eng_done_i    (eng_done_i),
    .done_o        (done_w),
    .idle_o        (idle_w),
    .resp_o        (resp_w)
  );

  i2c_rf_regs #(.DIV_W(DIV_W)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .acc_i         (acc_w),
    .we_i          (we_i),
    .sel_i         (sel_w),
    .wdata_i       (wdata_i[7:0]),
    .done_i        (done_w),
    .cur_op_i      (cmd_op_w),
    .eng_ack_i     (eng_ack_i),
    .eng_lost_i    (eng_lost_i),
    .eng_rdata_i   (eng_rdata_i),
    .resp_i        (resp_w),
    .launch_o      (launch_w),
    .launch_op_o   (launch_op_w),
    .launch_byte_o (launch_byte_w),
    .follow_o      (follow_w),
    .rdata_o       (rdata_w),
    .div_o         (div_o),
    .irq_o         (irq_o)
  );

  assign cmd_op_o = cmd_op_w;
  assign ready_o  = (acc_w && !launch_w) || resp_w;
  assign rdata_o  = {{HI_W{1'b0}}, rdata_w};
endmodule

// File: rtl/i2c_host_regs_chk.sv
module i2c_host_regs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       we_i,
  input logic       ready_o,
  input logic       cmd_valid_o,
  input logic       cmd_ready_i,
  input logic [1:0] cmd_op_o,
  input logic [7:0] cmd_data_o,
  input logic       eng_done_i,
  input logic       irq_o
);
  assert_cmd_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_data_o));

  assert_no_ready_in_issue_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && cmd_valid_o));

  assert_ready_needs_req_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> req_i);

  assert_irq_rise_on_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(eng_done_i));

  assert_irq_fall_on_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(req_i && we_i));
endmodule

bind i2c_host_regs i2c_host_regs_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .ready_o     (ready_o),
  .cmd_valid_o (cmd_valid_o),
  .cmd_ready_i (cmd_ready_i),
  .cmd_op_o    (cmd_op_o),
  .cmd_data_o  (cmd_data_o),
  .eng_done_i  (eng_done_i),
  .irq_o       (irq_o)
);

// File: tb/i2c_host_regs_test.sv
`timescale 1ns/1ps
module i2c_host_regs_test;
  localparam int A_OWN = 'h00, A_DIV = 'h04, A_CTL = 'h08, A_ST = 'h0C, A_DAT = 'h10;
  localparam int OP_S = 0, OP_W = 1, OP_R = 2, OP_P = 3;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        ready_o, cmd_valid_o, irq_o;
  logic        cmd_ready_i = 1'b0, eng_done_i = 1'b0, eng_ack_i = 1'b0, eng_lost_i = 1'b0;
  logic [1:0]  cmd_op_o;
  logic [7:0]  cmd_data_o, eng_rdata_i = '0;
  logic [5:0]  div_o;

  int n_tests = 0, n_fail = 0;
  int cmd_cnt = 0, last_op = -1, prev_op = -1, last_data = -1, stall = 0;
  bit cfg_ack = 1'b1, cfg_lost = 1'b0;
  logic [7:0] cfg_rd = '0;

  always #2.5 clk = ~clk;

  i2c_host_regs uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ready_o(ready_o), .cmd_valid_o(cmd_valid_o),
    .cmd_ready_i(cmd_ready_i), .cmd_op_o(cmd_op_o), .cmd_data_o(cmd_data_o),
    .eng_done_i(eng_done_i), .eng_ack_i(eng_ack_i), .eng_lost_i(eng_lost_i),
    .eng_rdata_i(eng_rdata_i), .div_o(div_o), .irq_o(irq_o)
  );

  // engine model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni && cmd_valid_o) begin
        prev_op = last_op;
        last_op = int'(cmd_op_o);
        last_data = int'(cmd_data_o);
        cmd_cnt++;
        cmd_ready_i = 1'b1;
        @(negedge clk);
        cmd_ready_i = 1'b0;
        @(negedge clk);
        eng_ack_i = cfg_ack;
        eng_lost_i = cfg_lost;
        eng_rdata_i = cfg_rd;
        eng_done_i = 1'b1;
        @(negedge clk);
        eng_done_i = 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit w, input int a, input int d, output int r);
    @(negedge clk);
    req_i = 1'b1; we_i = w; addr_i = a[4:0]; wdata_i = d[15:0];
    stall = 0;
    #1;
    while (!ready_o) begin
      @(negedge clk); #1;
      stall++;
    end
    r = int'(rdata_o);
    @(posedge clk); #1;
    req_i = 1'b0;
  endtask

  task automatic wr(input int a, input int d);
    int r;
    acc(1'b1, a, d, r);
  endtask

  task automatic rd(input int a, output int r);
    acc(1'b0, a, 0, r);
  endtask

  task automatic chk_rd(input string tag, input int a, input int exp);
    int r;
    rd(a, r);
    chk(tag, r, exp);
  endtask

  initial begin
    #(5.0 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int c0, v;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1 reset state
    chk_rd("R1 own", A_OWN, 0);
    chk_rd("R1 div", A_DIV, 0);
    chk_rd("R1 ctl", A_CTL, 0);
    chk_rd("R1 st", A_ST, 0);
    chk_rd("R1 dat", A_DAT, 0);
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 cmds", cmd_cnt, 0);

    // R12 disabled data write
    wr(A_CTL, 'h30);
    c0 = cmd_cnt;
    wr(A_DAT, 'hA4);
    chk("R12 no cmd", cmd_cnt, c0);
    chk_rd("R12 st", A_ST, 'h20);
    chk("R12 irq", int'(irq_o), 0);

    // R2 mask sweeps
    for (int b = 0; b < 256; b++) begin
      wr(A_OWN, (b << 8) | b);
      chk_rd("R2 own", A_OWN, b & 'hFE);
      wr(A_DIV, ((255 - b) << 8) | b);
      chk_rd("R2 div", A_DIV, b & 'h3F);
      chk("R2 div_o", int'(div_o), b & 'h3F);
    end
    wr(A_OWN, 'h00);
    wr(A_DIV, 'h00);
    wr('h14, 'hFF);
    wr('h1C, 'hFF);
    chk_rd("R2 unmapped rd", 'h14, 0);
    chk_rd("R2 unmapped wr own", A_OWN, 0);
    chk_rd("R2 unmapped wr div", A_DIV, 0);

    // R3 busy follows master
    wr(A_CTL, 'hE0);
    chk_rd("R3 busy set", A_ST, 'h20);
    chk_rd("R2 ctl", A_CTL, 'hE0);
    wr(A_CTL, 'hC0);
    chk_rd("R3 busy clr", A_ST, 'h00);
    wr(A_CTL, 'hF3);
    chk_rd("R2 ctl mask", A_CTL, 'hF0);

    // R4 address phase sweep, R9/R10 closing
    for (int b = 0; b < 256; b++) begin
      cfg_ack = (b % 3) != 0;
      c0 = cmd_cnt;
      wr(A_DAT, b);
      chk("R4 start cnt", cmd_cnt, c0 + 1);
      chk("R4 start op", last_op, OP_S);
      chk("R4 start byte", last_data, b);
      chk("R13 stalled", int'(stall > 2), 1);
      if (cfg_ack) begin
        chk_rd("R4 ack st", A_ST, 'h22);
        chk("R7 irq", int'(irq_o), 1);
        wr(A_ST, 'h00);
        chk_rd("R8 clr", A_ST, 'h20);
        chk("R8 irq low", int'(irq_o), 0);
        if (b % 2 == 0) begin
          wr(A_CTL, 'hF4);
          chk("R10 stop", last_op, OP_P);
          chk("R10 cnt", cmd_cnt, c0 + 2);
          chk_rd("R10 selfclr", A_CTL, 'hF0);
        end else begin
          wr(A_CTL, 'hD0);
          chk("R9 stop", last_op, OP_P);
          chk("R9 cnt", cmd_cnt, c0 + 2);
          chk_rd("R9 st", A_ST, 'h00);
          wr(A_CTL, 'hF0);
        end
      end else begin
        chk_rd("R4 nack st", A_ST, 'h21);
        chk("R4 nack irq", int'(irq_o), 0);
      end
    end
    c0 = cmd_cnt;
    wr(A_CTL, 'hF4);
    chk("R10 closed no cmd", cmd_cnt, c0);
    chk_rd("R10 keep bit", A_CTL, 'hF4);
    wr(A_CTL, 'hF0);

    // R5 data phase
    cfg_ack = 1'b1;
    wr(A_DAT, 'h40);
    wr(A_ST, 0);
    for (int k = 0; k < 16; k++) begin
      cfg_ack = (k % 4) != 3;
      c0 = cmd_cnt;
      wr(A_DAT, k * 17);
      if (cfg_ack) begin
        chk("R5 cnt", cmd_cnt, c0 + 1);
        chk("R5 op", last_op, OP_W);
        chk("R5 byte", last_data, k * 17);
        chk_rd("R5 ack st", A_ST, 'h22);
        wr(A_ST, 0);
      end else begin
        chk("R5 nack cnt", cmd_cnt, c0 + 2);
        chk("R5 nack write", prev_op, OP_W);
        chk("R5 nack stop", last_op, OP_P);
        chk_rd("R5 nack st", A_ST, 'h21);
        cfg_ack = 1'b1;
        wr(A_DAT, 'h40);
        chk("R5 reopen start", last_op, OP_S);
        wr(A_ST, 0);
      end
    end
    wr(A_CTL, 'hD0);

    // R6 receive path
    wr(A_CTL, 'hE0);
    cfg_ack = 1'b1;
    wr(A_DAT, 'h41);
    wr(A_ST, 0);
    for (int j = 0; j < 8; j++) begin
      cfg_rd = 8'((j * 37 + 5) & 'hFF);
      cfg_ack = (j != 5);
      c0 = cmd_cnt;
      rd(A_DAT, v);
      chk("R6 rd cnt", cmd_cnt, c0 + 1);
      chk("R6 rd op", last_op, OP_R);
      if (cfg_ack) begin
        chk("R6 rd val", v, (j * 37 + 5) & 'hFF);
        chk_rd("R6 rd st", A_ST, 'h22);
        wr(A_ST, 0);
      end else begin
        chk("R6 rd fail", v, 'hFF);
        chk_rd("R6 rd fail st", A_ST, 'h20);
      end
    end
    wr(A_CTL, 'hD0);
    c0 = cmd_cnt;
    chk_rd("R6 slave stored", A_DAT, 'h08);
    chk("R6 slave no cmd", cmd_cnt, c0);
    wr(A_CTL, 'hF0);
    chk_rd("R6 closed ff", A_DAT, 'hFF);
    chk("R6 closed no cmd", cmd_cnt, c0);
    cfg_ack = 1'b1;
    wr(A_DAT, 'h42);
    c0 = cmd_cnt;
    chk_rd("R6 tx ff", A_DAT, 'hFF);
    chk("R6 tx no cmd", cmd_cnt, c0);
    wr(A_CTL, 'hD0);
    wr(A_ST, 0);

    // R7 interrupt gated by enable bits
    wr(A_CTL, 'hB0);
    c0 = cmd_cnt;
    wr(A_DAT, 'h50);
    chk("R7 start issued", cmd_cnt, c0 + 1);
    chk_rd("R7 no pend", A_ST, 'h20);
    chk("R7 irq low", int'(irq_o), 0);
    wr(A_CTL, 'h90);

    // R14 / R8 arbitration lost and status writes
    wr(A_CTL, 'hF0);
    cfg_lost = 1'b1;
    wr(A_DAT, 'h60);
    chk_rd("R14 al nack", A_ST, 'h31);
    cfg_lost = 1'b0;
    wr(A_DAT, 'h60);
    chk("R14 still start", last_op, OP_S);
    chk_rd("R14 reopen", A_ST, 'h32);
    wr(A_ST, 'hFF);
    chk_rd("R8 ones keep", A_ST, 'h32);
    chk("R8 irq kept", int'(irq_o), 1);
    wr(A_ST, 'h10);
    chk_rd("R8 iif clr", A_ST, 'h30);
    chk("R8 irq clr", int'(irq_o), 0);
    wr(A_ST, 'h00);
    chk_rd("R8 al clr", A_ST, 'h20);

    // R11 soft reset
    wr(A_OWN, 'h5B);
    wr(A_DIV, 'h15);
    wr(A_DAT, 'h61);
    chk("R11 pre irq", int'(irq_o), 1);
    c0 = cmd_cnt;
    wr(A_CTL, 'h00);
    chk("R11 stop", last_op, OP_P);
    chk("R11 cnt", cmd_cnt, c0 + 1);
    chk_rd("R11 own kept", A_OWN, 'h5A);
    chk_rd("R11 div", A_DIV, 0);
    chk_rd("R11 ctl", A_CTL, 0);
    chk_rd("R11 st", A_ST, 0);
    chk_rd("R11 dat", A_DAT, 0);
    chk("R11 irq", int'(irq_o), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule